// File: doc/BRIEF.md
# Interrupt Latency Measurement Timer

This block produces an interrupt and then measures how long software takes to react to it. Each channel has an up-counter. Software gives the counter a start value and a terminal value through a small register port. While the counter runs, it climbs from the start value. The step taken at the terminal value raises a level interrupt, provided interrupts are enabled. The counter then either reloads the start value and goes on counting, or stops at the terminal value.

The interrupt handler's first action is to drive a GPIO line into the channel's freeze input. The freeze line passes through a two-stage synchroniser and then halts the counter. The frozen count therefore records the time from the interrupt to the handler, plus the two synchroniser cycles. Software reads this count back. Reads have no side effects. The handler acknowledges the interrupt by writing one to the pending bit.

The block holds a parameterised number of independent channels, two by default, one for each processor interrupt line. The channel is chosen by the address bits above the per-channel offset.

Top module: `irq_latency_timer`

## Requirements
- R1: After reset every `irq` bit is low, `rd_data` is 0, and each channel reads 0 for its control, status and count words.
- R2: A write to the control word (offset 0) with bit 3 set copies the start word (offset 2) into the counter on that same clock edge. Bit 3 always reads back as 0, while bits 0..2 read back as written.
- R3: While run (control bit 0) is set, the synchronised freeze is low and the channel is not stopped, the count rises by exactly 1 on each clock.
- R4: When the count equals the terminal word (offset 3) and auto-reload (control bit 1) is set, the next step loads the start word. The count therefore cycles with a period of terminal minus start plus one.
- R5: When auto-reload is clear, the step taken at the terminal value stops the channel and the count holds. A control write with run set restarts the channel, and setting the load bit in the same write makes it begin again from the start word.
- R6: A step taken at the terminal value sets the pending flag one clock later, but only when interrupt enable (control bit 2) is set. With the enable clear, `irq` stays low.
- R7: The pending flag drives `irq`, is active high, and stays set until software writes 1 to status bit 0 (offset 1). Writing 0 to that bit has no effect. Status bit 0 reads back as the pending flag.
- R8: If a terminal step and a write-one-to-clear happen on the same clock edge, the pending flag stays set.
- R9: The freeze input passes through two flops. The counter still steps on the two edges after freeze is sampled high, and then holds for as long as the synchronised freeze stays high.
- R10: Reading the count word (offset 4) or any other word changes no state. `rd_data` changes only on an edge where `rd_en` is high.
- R11: Channels are independent. Address bit 3 (above the 3-bit offset) selects the channel for both reads and writes.
- R12: `rd_data` shows the addressed word one clock after `rd_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: channel select and offset |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address: channel select and offset |
| rd_data | output | CNT_W | Registered read data |
| freeze | input | N_CH | Per-channel asynchronous freeze request |
| irq | output | N_CH | Per-channel level interrupt, active high |

## Verification
The assertions assume three things about the inputs. Register strobes come from the `clk` domain. Writes address real channels. Freeze is the only input that may change without regard to the clock. The bench therefore drives every strobe and the freeze line on falling edges, and uses only channel indices that exist. It keeps the terminal word at or above the start word, so the counting properties never depend on the counter wrapping. Freeze is raised a counted number of edges after the run write, so the value it captures is exact and can be checked against the hand-derived table.

// File: rtl/ilt_pkg.sv
package ilt_pkg;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STATUS = 3'd1;
  localparam logic [OFF_W-1:0] OFF_START  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TERM   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 3'd4;

  localparam int BIT_RUN  = 0;
  localparam int BIT_AR   = 1;
  localparam int BIT_IE   = 2;
  localparam int BIT_LOAD = 3;
  localparam int BIT_PEND = 0;

  typedef struct packed {
    logic ie;
    logic ar;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ilt_sync.sv
module ilt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ilt_counter.sv
module ilt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             auto_reload,
  input  logic             hold,
  input  logic             load,
  input  logic             restart,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] term_val,
  output logic [CNT_W-1:0] count,
  output logic             term_evt
);
  logic [CNT_W-1:0] count_q;
  logic             stopped_q;
  logic             step;
  logic             at_term;

  assign step     = run && !hold && !stopped_q;
  assign at_term  = (count_q == term_val);
  assign term_evt = step && at_term && !load;
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      stopped_q <= 1'b0;
    end else if (load) begin
      count_q   <= start_val;
      stopped_q <= 1'b0;
    end else begin
      if (restart) stopped_q <= 1'b0;
      if (step) begin
        if (at_term) begin
          if (auto_reload) count_q <= start_val;
          else             stopped_q <= 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !at_term && !load) |=> (count_q == $past(count_q) + 1'b1));

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (step && at_term && auto_reload && !load) |=> (count_q == $past(start_val)));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (stopped_q && !load) |=> $stable(count_q));

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hold && !load) |=> $stable(count_q));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(start_val)));
endmodule

// File: rtl/ilt_channel.sv
module ilt_channel
  import ilt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [CNT_W-1:0] rd_word,
  input  logic             freeze_raw,
  output logic             irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] count;
  logic             irq_q;
  logic             frz_s;
  logic             term_evt;
  logic             ctrl_wr;
  logic             load_pulse;
  logic             restart;
  logic             clr_w1c;

  assign ctrl_wr    = wr_en && (wr_off == OFF_CTRL);
  assign load_pulse = ctrl_wr && wr_data[BIT_LOAD];
  assign restart    = ctrl_wr && wr_data[BIT_RUN];
  assign clr_w1c    = wr_en && (wr_off == OFF_STATUS) && wr_data[BIT_PEND];

  ilt_sync #(.STAGES(SYNC_STGS)) u_frz_sync (
    .clk (clk),
    .rst (rst),
    .d   (freeze_raw),
    .q   (frz_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      start_q <= '0;
      term_q  <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_CTRL: begin
          ctrl_q.run <= wr_data[BIT_RUN];
          ctrl_q.ar  <= wr_data[BIT_AR];
          ctrl_q.ie  <= wr_data[BIT_IE];
        end
        OFF_START: start_q <= wr_data;
        OFF_TERM:  term_q  <= wr_data;
        default: ;
      endcase
    end
  end

  ilt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .run         (ctrl_q.run),
    .auto_reload (ctrl_q.ar),
    .hold        (frz_s),
    .load        (load_pulse),
    .restart     (restart),
    .start_val   (start_q),
    .term_val    (term_q),
    .count       (count),
    .term_evt    (term_evt)
  );

  always_ff @(posedge clk) begin
    if (rst)                        irq_q <= 1'b0;
    else if (term_evt && ctrl_q.ie) irq_q <= 1'b1;
    else if (clr_w1c)               irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    rd_word = '0;
    case (rd_off)
      OFF_CTRL: begin
        rd_word[BIT_RUN] = ctrl_q.run;
        rd_word[BIT_AR]  = ctrl_q.ar;
        rd_word[BIT_IE]  = ctrl_q.ie;
      end
      OFF_STATUS: rd_word[BIT_PEND] = irq_q;
      OFF_START:  rd_word = start_q;
      OFF_TERM:   rd_word = term_q;
      OFF_COUNT:  rd_word = count;
      default:    rd_word = '0;
    endcase
  end

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
    (term_evt && ctrl_q.ie) |=> irq_q);

  assert_no_irq_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !(term_evt && ctrl_q.ie)) |=> !irq_q);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_w1c) |=> irq_q);

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_w1c && !term_evt) |=> !irq_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_w1c && term_evt && ctrl_q.ie) |=> irq_q);
endmodule

// File: rtl/irq_latency_timer.sv
module irq_latency_timer
  import ilt_pkg::*;
#(
  parameter int N_CH      = 2,
  parameter int CNT_W     = 32,
  parameter int SYNC_STGS = 2,
  parameter int ADDR_W    = ilt_pkg::OFF_W + ((N_CH > 1) ? $clog2(N_CH) : 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_CH-1:0]   freeze,
  output logic [N_CH-1:0]   irq
);
  localparam int CH_SEL_W = ADDR_W - OFF_W;

  logic [CNT_W-1:0]    words [N_CH];
  logic [CH_SEL_W-1:0] wr_sel;
  logic [CH_SEL_W-1:0] rd_sel;
  logic [CNT_W-1:0]    rd_mux;

  assign wr_sel = wr_addr[ADDR_W-1:OFF_W];
  assign rd_sel = rd_addr[ADDR_W-1:OFF_W];

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic ch_wr;
      assign ch_wr = wr_en && (wr_sel == CH_SEL_W'(g));

      ilt_channel #(.CNT_W(CNT_W), .SYNC_STGS(SYNC_STGS)) u_ch (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ch_wr),
        .wr_off     (wr_addr[OFF_W-1:0]),
        .wr_data    (wr_data),
        .rd_off     (rd_addr[OFF_W-1:0]),
        .rd_word    (words[g]),
        .freeze_raw (freeze[g]),
        .irq        (irq[g])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_sel == CH_SEL_W'(i)) rd_mux = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_reset_irq_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0));
endmodule

// File: tb/irq_latency_timer_tb.sv
module irq_latency_timer_tb;
  localparam int N_CH   = 2;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 4;
  localparam int NV     = 6;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_START = 3'd2,
                         A_TERM = 3'd3, A_CNT  = 3'd4;

  // start, terminal, auto-reload, edges before freeze, frozen count, irq expected
  localparam logic [31:0] V_S   [NV] = '{32'd10,  32'd0, 32'd0, 32'd50, 32'd200, 32'd7};
  localparam logic [31:0] V_T   [NV] = '{32'd100, 32'd3, 32'd3, 32'd52, 32'd200, 32'd20};
  localparam logic        V_AR  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_N   [NV] = '{5, 6, 6, 3, 2, 0};
  localparam logic [31:0] V_EXP [NV] = '{32'd17, 32'd0, 32'd3, 32'd52, 32'd200, 32'd9};
  localparam logic        V_IRQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]  rd_data;
  logic [N_CH-1:0]   freeze = '0;
  logic [N_CH-1:0]   irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rv;
  logic [31:0] rv2;

  always #2 clk = ~clk;

  irq_latency_timer #(.N_CH(N_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .freeze(freeze), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [2:0] off, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = {ch[0], off}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [2:0] off, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = {ch[0], off};
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic quiesce(input int ch);
    freeze[ch] = 1'b0;
    wr(ch, A_CTRL, 32'h0);
    wr(ch, A_STAT, 32'h1);
    repeat (3) @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {30'd0, irq}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rd(0, A_CTRL, rv);  check("R1 ctrl", rv, 32'd0);
    rd(0, A_STAT, rv);  check("R1 status", rv, 32'd0);
    rd(1, A_CNT, rv);   check("R1 count ch1", rv, 32'd0);

    // Vector table: R3 R4 R5 R6 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      quiesce(0);
      wr(0, A_START, V_S[i]);
      wr(0, A_TERM, V_T[i]);
      wr(0, A_CTRL, 32'h8 | 32'h4 | 32'h1 | {30'd0, V_AR[i], 1'b0});
      repeat (V_N[i]) @(negedge clk);
      freeze[0] = 1'b1;
      repeat (6) @(negedge clk);
      rd(0, A_CNT, rv);
      check($sformatf("R9/R3/R4/R5 vec%0d frozen count", i), rv, V_EXP[i]);
      repeat (4) @(negedge clk);
      rd(0, A_CNT, rv2);
      check($sformatf("R10 vec%0d count stable on reread", i), rv2, V_EXP[i]);
      check($sformatf("R6 vec%0d irq", i), {31'd0, irq[0]}, {31'd0, V_IRQ[i]});
    end

    // R2 load without run, control readback
    quiesce(0);
    wr(0, A_START, 32'd1234);
    wr(0, A_CTRL, 32'hE);
    rd(0, A_CNT, rv);   check("R2 load copies start", rv, 32'd1234);
    rd(0, A_CTRL, rv);  check("R2 ctrl readback, load bit reads 0", rv, 32'h6);

    // R7 sticky and write-one-to-clear
    quiesce(0);
    wr(0, A_START, 32'd0);
    wr(0, A_TERM, 32'd3);
    wr(0, A_CTRL, 32'hF);
    repeat (10) @(negedge clk);
    freeze[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 irq set", {31'd0, irq[0]}, 32'd1);
    wr(0, A_STAT, 32'h0);
    check("R7 writing 0 keeps irq", {31'd0, irq[0]}, 32'd1);
    rd(0, A_STAT, rv);  check("R7 status reads pending", rv, 32'd1);
    wr(0, A_STAT, 32'h1);
    check("R7 W1C clears irq", {31'd0, irq[0]}, 32'd0);
    rd(0, A_STAT, rv);  check("R7 status cleared", rv, 32'd0);

    // R8 terminal step and clear on the same edge
    quiesce(0);
    wr(0, A_START, 32'd0);
    wr(0, A_TERM, 32'd3);
    wr(0, A_CTRL, 32'hF);
    repeat (7) @(negedge clk);
    wr(0, A_STAT, 32'h1);
    check("R8 set wins over clear", {31'd0, irq[0]}, 32'd1);
    wr(0, A_STAT, 32'h1);
    check("R8 clear away from event", {31'd0, irq[0]}, 32'd0);

    // R5 stop at terminal, then restart with load
    quiesce(0);
    wr(0, A_START, 32'd0);
    wr(0, A_TERM, 32'd5);
    wr(0, A_CTRL, 32'h9);
    repeat (20) @(negedge clk);
    rd(0, A_CNT, rv);   check("R5 held at terminal", rv, 32'd5);
    repeat (5) @(negedge clk);
    rd(0, A_CNT, rv);   check("R5 still held", rv, 32'd5);
    check("R6 no irq with enable clear", {31'd0, irq[0]}, 32'd0);
    wr(0, A_CTRL, 32'h9);
    @(negedge clk);
    freeze[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(0, A_CNT, rv);   check("R5/R9 restart then freeze", rv, 32'd3);

    // R11 channel independence
    freeze[0] = 1'b0;
    wr(0, A_CTRL, 32'h0);
    wr(1, A_START, 32'd1000);
    wr(1, A_CTRL, 32'h8);
    rd(0, A_CNT, rv);   check("R11 ch0 untouched", rv, 32'd3);
    rd(1, A_CNT, rv);   check("R11 ch1 loaded", rv, 32'd1000);
    check("R11 ch1 irq low", {31'd0, irq[1]}, 32'd0);

    // R12/R10 read latency and hold
    rd(0, A_TERM, rv);  check("R12 read returns addressed word", rv, 32'd5);
    repeat (3) @(negedge clk);
    check("R10 rd_data holds without rd_en", rd_data, 32'd5);

    report();
    $finish;
  end
endmodule